// File: doc/BRIEF.md
# Sliding-Window Lempel-Ziv Byte Compressor

This block turns a stream of uncompressed bytes into a bit-packed Lempel-Ziv code stream. Each accepted byte is compared in parallel against every byte already held in a circular history store. The block follows the set of history positions that continue the current string, and it emits the string as one copy codeword when the string stops growing. A byte that starts no useful string goes out as a literal codeword. Codewords are packed MSB-first into bytes on a separate ready/valid output.

A producer raises a last flag with the final byte of a stream. The block then closes any open string, appends a terminating code that no copy can produce, and pads with zero bits up to the next byte boundary. When the final byte has left the output, the history is wiped, so the next stream is coded without any reference to the previous one. Input is held off whenever the bit packer has no room, so a slow consumer throttles the producer and no data is lost.

Top module: `lz_encoder`

## Requirements
- R1: A byte that is not part of a copy is coded as a 0 bit followed by the 8 data bits, most significant first.
- R2: A copy is coded as a 1 bit, then a length prefix code (2..3: `0`+1 bit of len-2; 4..7: `10`+2 bits of len-4; 8..15: `110`+3 bits of len-8; 16..31: `1110`+4 bits of len-16; 32..271: `1111`+8 bits of len-32), then a log2(DEPTH)-bit distance back from the first byte of the string to the first byte of its earlier copy.
- R3: Each string is the longest continuation of earlier data that starts at the current byte. Among equally long candidates the smallest distance is chosen. A best length of 1 is coded as a literal.
- R4: A copy never exceeds MAX_LEN bytes (default 271). When a string reaches that length, the next byte starts a new string.
- R5: After the last byte, the stream carries a 1 bit followed by twelve 1 bits as its end code.
- R6: The end code is followed by zero bits up to a byte boundary, and nothing else is sent for that stream.
- R7: History from one stream is never referenced by the next stream.
- R8: Only the previous DEPTH-1 bytes can be referenced, so a repeat at distance DEPTH or more is coded as literals.
- R9: While out_valid is high and out_ready is low, out_data holds steady. Input stalls while the packer lacks room, and no bit is lost or duplicated.
- R10: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Uncompressed byte offered |
| in_ready | output | 1 | Byte accepted at this edge when high with in_valid |
| in_data | input | 8 | Uncompressed byte |
| in_last | input | 1 | Marks the final byte of a stream |
| out_valid | output | 1 | Packed byte available |
| out_ready | input | 1 | Consumer takes the packed byte |
| out_data | output | 8 | Packed code byte, first bit in bit 7 |

## Verification
A wrong candidate vector or length count shows up as a different codeword in the packed output. The bytes carrying that codeword leave within a few cycles of the string closing, because the packer holds fewer than five bytes. Wrong distance selection, wrong length capping and a history that survives between streams each change particular bits, so every output byte is compared with a bit-exact reference encoding built in the bench from the requirements. Packer faults such as a lost bit, a missing pad or a changing held byte change the byte count or the byte values of a run, so the end-of-run comparison of count and content catches them even under random backpressure.

// File: rtl/lz_pkg.sv
package lz_pkg;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_MARK  = 2'd1,
      ST_PAD   = 2'd2,
      ST_DRAIN = 2'd3
   } enc_state_t;

   localparam int LEN_W      = 9;
   localparam int LEN_LIMIT  = 271;
   localparam int PREFIX_MAX = 12;
   localparam int MARK_BITS  = 1 + PREFIX_MAX;

   // Returns {size[3:0], code[11:0]}; code is right-aligned.
   function automatic logic [15:0] len_code(input logic [LEN_W-1:0] len);
      logic [11:0]      c;
      logic [3:0]       sz;
      logic [LEN_W-1:0] t;
      if (len <= LEN_W'(3)) begin
         t  = len - LEN_W'(2);
         c  = {11'b0, t[0]};
         sz = 4'd2;
      end else if (len <= LEN_W'(7)) begin
         t  = len - LEN_W'(4);
         c  = {8'b0, 2'b10, t[1:0]};
         sz = 4'd4;
      end else if (len <= LEN_W'(15)) begin
         t  = len - LEN_W'(8);
         c  = {6'b0, 3'b110, t[2:0]};
         sz = 4'd6;
      end else if (len <= LEN_W'(31)) begin
         t  = len - LEN_W'(16);
         c  = {4'b0, 4'b1110, t[3:0]};
         sz = 4'd8;
      end else begin
         t  = len - LEN_W'(32);
         c  = {4'b1111, t[7:0]};
         sz = 4'd12;
      end
      return {sz, c};
   endfunction

endpackage

// File: rtl/lz_hist_cam.sv
module lz_hist_cam #(
   parameter int DEPTH = 512,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic [7:0]       key,
   output logic [AW-1:0]    wp,
   output logic [DEPTH-1:0] hit
);

   logic [7:0]       mem [DEPTH];
   logic [DEPTH-1:0] valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         valid <= '0;
      end else if (clr) begin
         wp    <= '0;
         valid <= '0;
      end else if (wr_en) begin
         valid[wp] <= 1'b1;
         wp        <= wp + AW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wp] <= wr_data;
   end

   // The slot about to be overwritten is DEPTH bytes old and is never a candidate.
   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign hit[i] = valid[i] && (mem[i] == key) && (AW'(i) != wp);
   end

   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (hit == '0));

endmodule

// File: rtl/lz_match_track.sv
module lz_match_track #(
   parameter int DEPTH   = 512,
   parameter int LEN_W   = 9,
   parameter int MAX_LEN = 271,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             extend,
   input  logic             stop,
   input  logic [DEPTH-1:0] hit,
   input  logic [AW-1:0]    wp,
   output logic             active,
   output logic             ext_ok,
   output logic [LEN_W-1:0] len,
   output logic [AW-1:0]    disp
);

   logic [DEPTH-1:0] cand;
   logic [DEPTH-1:0] nxt;

   for (genvar i = 0; i < DEPTH; i++) begin : g_chain
      localparam int PREV = (i == 0) ? DEPTH - 1 : i - 1;
      assign nxt[i] = cand[PREV] & hit[i];
   end

   assign active = (len != '0);
   assign ext_ok = (|nxt) && (len < LEN_W'(MAX_LEN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand <= '0;
         len  <= '0;
      end else if (stop) begin
         cand <= '0;
         len  <= '0;
      end else if (start) begin
         cand <= hit;
         len  <= LEN_W'(1);
      end else if (extend) begin
         cand <= nxt;
         len  <= len + LEN_W'(1);
      end
   end

   // Nearest surviving candidate: string end sits at wp-1, candidate end e, distance wp-1-e.
   always_comb begin
      disp = '0;
      for (int k = DEPTH - 1; k >= 1; k--) begin
         if (cand[wp - AW'(1) - AW'(k)]) disp = AW'(k);
      end
   end

   p_len_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      len <= LEN_W'(MAX_LEN));

   p_cand_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (|cand));

   p_disp_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (disp != '0));

endmodule

// File: rtl/lz_bit_packer.sv
module lz_bit_packer #(
   parameter int CW_W  = 22,
   parameter int ACC_W = CW_W + 16,
   localparam int CNT_W = $clog2(ACC_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [CW_W-1:0]  cw,
   input  logic [CNT_W-1:0] cw_len,
   input  logic             align,
   output logic             can_push,
   output logic             empty,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [7:0]       out_data
);

   logic [ACC_W-1:0] acc, acc_s, acc_n, ins;
   logic [CNT_W-1:0] cnt, cnt_s, cnt_n;
   logic             drain;

   assign out_valid = (cnt >= CNT_W'(8));
   assign out_data  = acc[ACC_W-1 -: 8];
   assign drain     = out_valid && out_ready;
   assign can_push  = (cnt <= CNT_W'(ACC_W - CW_W));
   assign empty     = (cnt == '0);

   always_comb begin
      acc_s = drain ? (acc << 8) : acc;
      cnt_s = drain ? (cnt - CNT_W'(8)) : cnt;
      if (align) cnt_s = (cnt_s + CNT_W'(7)) & ~CNT_W'(7);
      ins   = ACC_W'(cw) << (CNT_W'(ACC_W) - cw_len);
      ins   = ins >> cnt_s;
      acc_n = push ? (acc_s | ins) : acc_s;
      cnt_n = push ? (cnt_s + cw_len) : cnt_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         cnt <= '0;
      end else begin
         acc <= acc_n;
         cnt <= cnt_n;
      end
   end

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> can_push);

   p_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (align && !push) |=> (cnt[2:0] == 3'd0));

endmodule

// File: rtl/lz_encoder.sv
module lz_encoder #(
   parameter int DEPTH   = 512,
   parameter int MAX_LEN = 271
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   output logic       in_ready,
   input  logic [7:0] in_data,
   input  logic       in_last,
   output logic       out_valid,
   input  logic       out_ready,
   output logic [7:0] out_data
);
   import lz_pkg::*;

   localparam int AW    = $clog2(DEPTH);
   localparam int CW_W  = 1 + PREFIX_MAX + AW;
   localparam int ACC_W = CW_W + 16;
   localparam int CNT_W = $clog2(ACC_W + 1);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("lz_encoder: DEPTH must be a power of two of at least 4");
   end
   if (MAX_LEN < 2 || MAX_LEN > LEN_LIMIT) begin : g_bad_len
      $error("lz_encoder: MAX_LEN must lie in 2..271");
   end

   enc_state_t       st, st_n;
   logic             end_flag, end_n;
   logic [7:0]       pend;

   logic             hist_wr, hist_clr;
   logic [AW-1:0]    wp;
   logic [DEPTH-1:0] hit;

   logic             trk_start, trk_ext, trk_stop;
   logic             active, ext_ok;
   logic [LEN_W-1:0] trk_len;
   logic [AW-1:0]    trk_disp;

   logic             push, align, can_push, empty;
   logic [CW_W-1:0]  cw;
   logic [CNT_W-1:0] cw_len;

   logic [15:0]      lc;
   logic [3:0]       lc_sz;
   logic [CW_W-1:0]  emit_cw;
   logic [CNT_W-1:0] emit_len;

   lz_hist_cam #(.DEPTH(DEPTH)) u_cam (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (hist_clr),
      .wr_en   (hist_wr),
      .wr_data (in_data),
      .key     (in_data),
      .wp      (wp),
      .hit     (hit)
   );

   lz_match_track #(.DEPTH(DEPTH), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_trk (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (trk_start),
      .extend (trk_ext),
      .stop   (trk_stop),
      .hit    (hit),
      .wp     (wp),
      .active (active),
      .ext_ok (ext_ok),
      .len    (trk_len),
      .disp   (trk_disp)
   );

   lz_bit_packer #(.CW_W(CW_W), .ACC_W(ACC_W)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .cw        (cw),
      .cw_len    (cw_len),
      .align     (align),
      .can_push  (can_push),
      .empty     (empty),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data)
   );

   // Codeword that closes the open string: literal for a single byte, copy otherwise.
   always_comb begin
      lc    = len_code(trk_len);
      lc_sz = lc[15:12];
      if (trk_len == LEN_W'(1)) begin
         emit_cw  = CW_W'(pend);
         emit_len = CNT_W'(9);
      end else begin
         emit_cw  = (CW_W'(1) << (AW + int'(lc_sz))) | (CW_W'(lc[11:0]) << AW) | CW_W'(trk_disp);
         emit_len = CNT_W'(1 + AW) + CNT_W'(lc_sz);
      end
   end

   always_comb begin
      st_n      = st;
      end_n     = end_flag;
      in_ready  = 1'b0;
      hist_wr   = 1'b0;
      hist_clr  = 1'b0;
      trk_start = 1'b0;
      trk_ext   = 1'b0;
      trk_stop  = 1'b0;
      push      = 1'b0;
      align     = 1'b0;
      cw        = '0;
      cw_len    = '0;
      unique case (st)
         ST_RUN: begin
            if (!active) begin
               in_ready = can_push;
               if (in_valid && can_push) begin
                  hist_wr = 1'b1;
                  if ((|hit) && !in_last) begin
                     trk_start = 1'b1;
                  end else begin
                     push   = 1'b1;
                     cw     = CW_W'(in_data);
                     cw_len = CNT_W'(9);
                     if (in_last) st_n = ST_MARK;
                  end
               end
            end else if (end_flag) begin
               if (can_push) begin
                  push     = 1'b1;
                  cw       = emit_cw;
                  cw_len   = emit_len;
                  trk_stop = 1'b1;
                  end_n    = 1'b0;
                  st_n     = ST_MARK;
               end
            end else begin
               in_ready = ext_ok;
               if (in_valid) begin
                  if (ext_ok) begin
                     hist_wr = 1'b1;
                     trk_ext = 1'b1;
                     end_n   = in_last;
                  end else if (can_push) begin
                     push     = 1'b1;
                     cw       = emit_cw;
                     cw_len   = emit_len;
                     trk_stop = 1'b1;
                  end
               end
            end
         end
         ST_MARK: begin
            if (can_push) begin
               push   = 1'b1;
               cw     = CW_W'({MARK_BITS{1'b1}});
               cw_len = CNT_W'(MARK_BITS);
               st_n   = ST_PAD;
            end
         end
         ST_PAD: begin
            align = 1'b1;
            st_n  = ST_DRAIN;
         end
         ST_DRAIN: begin
            if (empty) begin
               hist_clr = 1'b1;
               st_n     = ST_RUN;
            end
         end
         default: st_n = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_RUN;
         end_flag <= 1'b0;
         pend     <= '0;
      end else begin
         st       <= st_n;
         end_flag <= end_n;
         if (trk_start) pend <= in_data;
      end
   end

   p_idle_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && !active && !in_ready) |-> out_valid);

   p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !active) |-> can_push);

endmodule

// File: tb/lz_encoder_tb.sv
`timescale 1ns/1ps
module lz_encoder_tb;

   localparam int DEPTH   = 64;
   localparam int MAX_LEN = 271;
   localparam int DW      = $clog2(DEPTH);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_data = '0;
   logic       in_last = 1'b0;
   logic       out_valid;
   logic       out_ready = 1'b1;
   logic [7:0] out_data;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit bp = 1'b0;

   logic [7:0] s [0:1023];
   logic [7:0] got [$];
   logic [7:0] expq [$];

   always #2.5 clk = ~clk;

   lz_encoder #(.DEPTH(DEPTH), .MAX_LEN(MAX_LEN)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // Consumer: decides ready at the falling edge, records a transfer that will occur at the next rise.
   initial forever begin
      @(negedge clk);
      out_ready = bp ? ($urandom_range(0, 2) != 0) : 1'b1;
      #1;
      if (rst_n && out_valid && out_ready) got.push_back(out_data);
   end

   // Reference encoder written from the requirements.
   task automatic build_exp(input int n);
      bit bits [$];
      int p, best, bd, lim, l;
      expq.delete();
      p = 0;
      while (p < n) begin
         best = 0;
         bd   = 0;
         lim  = (p < DEPTH - 1) ? p : DEPTH - 1;
         for (int d = 1; d <= lim; d++) begin
            l = 0;
            while (p + l < n && l < MAX_LEN && s[p + l] == s[p + l - d]) l++;
            if (l > best) begin best = l; bd = d; end
         end
         if (best >= 2) begin
            int code, sz;
            bits.push_back(1'b1);
            if (best <= 3)       begin code = best - 2;              sz = 2;  end
            else if (best <= 7)  begin code = 'b1000 | (best - 4);   sz = 4;  end
            else if (best <= 15) begin code = 'b110000 | (best - 8); sz = 6;  end
            else if (best <= 31) begin code = 'hE0 | (best - 16);    sz = 8;  end
            else                 begin code = 'hF00 | (best - 32);   sz = 12; end
            for (int b = sz - 1; b >= 0; b--) bits.push_back(code[b]);
            for (int b = DW - 1; b >= 0; b--) bits.push_back(bd[b]);
            p += best;
         end else begin
            bits.push_back(1'b0);
            for (int b = 7; b >= 0; b--) bits.push_back(s[p][b]);
            p++;
         end
      end
      for (int b = 0; b < 13; b++) bits.push_back(1'b1);
      while (bits.size() % 8 != 0) bits.push_back(1'b0);
      for (int i = 0; i < bits.size(); i += 8) begin
         logic [7:0] v;
         for (int b = 0; b < 8; b++) v[7 - b] = bits[i + b];
         expq.push_back(v);
      end
   endtask

   task automatic feed(input int n);
      for (int i = 0; i < n; i++) begin
         bit taken;
         taken = 1'b0;
         while (!taken) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = s[i];
            in_last  = (i == n - 1);
            #1;
            taken = in_ready;
            @(posedge clk);
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic run(input int n, input string req);
      got.delete();
      build_exp(n);
      feed(n);
      for (int w = 0; w < 400 && got.size() < expq.size(); w++) @(posedge clk);
      repeat (30) @(posedge clk);
      chk(got.size() == expq.size(), {req, " byte count (R6)"}, got.size(), expq.size());
      for (int i = 0; i < expq.size() && i < got.size(); i++)
         chk(got[i] == expq[i], req, got[i], expq[i]);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
      chk(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);

      // R1 R5 R6: single literal 0x41 -> 0 01000001 1111111111111 00 = 20 FF FC
      s[0] = 8'h41;
      run(1, "R1 single literal");
      if (got.size() >= 3) begin
         chk(got[0] == 8'h20, "R1 literal head", got[0], 8'h20);
         chk(got[1] == 8'hFF, "R5 end code", got[1], 8'hFF);
         chk(got[2] == 8'hFC, "R6 zero pad", got[2], 8'hFC);
      end

      // R2: short periodic pattern giving copies of various lengths
      for (int i = 0; i < 40; i++) s[i] = 8'h30 + 8'(i % 3);
      run(40, "R2 periodic copy");

      // R3: ties and length-1 strings from a tiny alphabet
      for (int i = 0; i < 120; i++) s[i] = 8'(((i * 7) ^ (i >> 2)) % 4);
      run(120, "R3 longest match");

      // R4: long run longer than the copy limit
      for (int i = 0; i < 320; i++) s[i] = 8'h5A;
      run(320, "R4 length cap");

      // R8: repeat at exactly DEPTH distance must stay literal
      for (int i = 0; i < 2 * DEPTH; i++) s[i] = 8'(i % DEPTH);
      run(2 * DEPTH, "R8 window limit");

      // R7: same stream twice; second must not reference the first
      for (int i = 0; i < 24; i++) s[i] = 8'h61 + 8'(i % 5);
      run(24, "R7 first stream");
      run(24, "R7 second stream");

      // R9: random data under random backpressure
      bp = 1'b1;
      for (int i = 0; i < 400; i++) s[i] = 8'($urandom_range(0, 5));
      run(400, "R9 backpressure");
      for (int i = 0; i < 300; i++) s[i] = (i % 50 < 30) ? 8'h77 : 8'($urandom_range(0, 2));
      run(300, "R3 mixed under backpressure");
      bp = 1'b0;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule